// File: doc/BRIEF.md
# Static Memory Access Wait-State Timer

This block times a single read or write cycle on one of several static memory chip selects. A requester presents a start pulse with a direction and a chip-select index. The block holds the matching active-low chip select for a counted number of cycles and then reports completion with a one-cycle done pulse.

Each chip select carries its own configuration bits. When extended timing is off, reads and writes use separate per-select delay counts. When extended timing is on, both directions share one long count. That count then acts as a ceiling, and a synchronized external acknowledge can end the access sooner. If the ceiling is reached without an acknowledge, the done pulse carries a timeout flag.

Some requests are refused without touching the bus: a write to a write-protected select, and any access to a select that has extended timing and page mode enabled together. These are answered with done and error in the cycle after the request.

Top module: `smc_wait_timer`

## Requirements
- R1: After reset, every chip-select output is high (inactive), and done, error, timeout and busy are all low.
- R2: A read on a select with extended timing off holds that select low for exactly rd_dly+1 cycles, starting in the cycle after the request. It then drives done high for one cycle with the select already high, and error and timeout stay low.
- R3: A write on an unprotected select with extended timing off holds that select low for exactly wr_dly+1 cycles. Completion is then signalled as in R2.
- R4: With extended timing on, reads and writes both use ext_dly instead of the per-direction counts. With no acknowledge, the select stays low for ext_dly+1 cycles, and timeout is high together with done.
- R5: The acknowledge input passes through two flip-flops before it is used. In extended mode, if ack_i rises j cycles after the request cycle (j=0 means in the request cycle itself), the select stays low for min(j+2, ext_dly+1) cycles. Timeout is flagged only if j+2 > ext_dly+1. With extended timing off, ack_i has no effect.
- R6: A write to a select whose wprot_i bit is 1 drives done and error high in the cycle after the request, and no select goes low. Reads on that select are timed normally.
- R7: A select with both ext_en_i and page_en_i set rejects reads and writes in the same way as R6. page_en_i alone does not change the timing.
- R8: While an access is in progress, new requests are ignored, and at most one chip-select output is low at any time.
- R9: Done lasts exactly one cycle. busy_o is high from the cycle after the request through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (sampled while idle) |
| we_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | CS_W | Chip-select index |
| wprot_i | input | NUM_CS | Per-select write protect |
| ext_en_i | input | NUM_CS | Per-select extended timing enable |
| page_en_i | input | NUM_CS | Per-select page mode enable (used only for the illegal-combination check) |
| rd_dly_i | input | NUM_CS*DLY_W | Per-select read delay counts, select i in bits [i*DLY_W +: DLY_W] |
| wr_dly_i | input | NUM_CS*DLY_W | Per-select write delay counts, same packing |
| ext_dly_i | input | EXT_W | Shared extended timeout count |
| ack_i | input | 1 | External acknowledge strobe, asynchronous |
| cs_n_o | output | NUM_CS | Active-low chip selects |
| busy_o | output | 1 | Access or completion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected (valid with done) |
| timeout_o | output | 1 | Extended access hit its ceiling (valid with done) |

## Verification
The bench builds the block with four chip selects, DLY_W=4 and EXT_W=5. At that size every read and write delay value (0 to 15) can be swept on several selects. Every extended ceiling (0 to 31) can be combined with every acknowledge arrival position up to and past the ceiling, which covers the boundary where the acknowledge and the timeout fall on the same cycle. The four selects are set up as page-only, extended, write-protected and extended-plus-page, so every accept and reject path is reached.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_FIN} acc_state_e;
endpackage

// File: rtl/smc_ack_sync.sv
module smc_ack_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic ack_s_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], ack_i};
  end

  assign ack_s_o = sync_q[1];
endmodule

// File: rtl/smc_cfg_check.sv
module smc_cfg_check #(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8,
  parameter int EXT_W  = 16,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int CNT_W = (DLY_W > EXT_W) ? DLY_W : EXT_W
) (
  input  logic                    we_i,
  input  logic [CS_W-1:0]         sel_i,
  input  logic [NUM_CS-1:0]       wprot_i,
  input  logic [NUM_CS-1:0]       ext_en_i,
  input  logic [NUM_CS-1:0]       page_en_i,
  input  logic [NUM_CS*DLY_W-1:0] rd_dly_i,
  input  logic [NUM_CS*DLY_W-1:0] wr_dly_i,
  input  logic [EXT_W-1:0]        ext_dly_i,
  output logic                    reject_o,
  output logic                    ext_o,
  output logic [CNT_W-1:0]        load_o
);
  logic [DLY_W-1:0] rd_sel, wr_sel;

  assign rd_sel   = rd_dly_i[sel_i*DLY_W +: DLY_W];
  assign wr_sel   = wr_dly_i[sel_i*DLY_W +: DLY_W];
  assign ext_o    = ext_en_i[sel_i];
  // illegal mode pair, or write into a protected select
  assign reject_o = (ext_en_i[sel_i] && page_en_i[sel_i]) || (we_i && wprot_i[sel_i]);

  always_comb begin
    if (ext_o)     load_o = CNT_W'(ext_dly_i);
    else if (we_i) load_o = CNT_W'(wr_sel);
    else           load_o = CNT_W'(rd_sel);
  end
endmodule

// File: rtl/smc_access_fsm.sv
module smc_access_fsm
  import smc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 16,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CS_W-1:0]   sel_i,
  input  logic              reject_i,
  input  logic              ext_i,
  input  logic [CNT_W-1:0]  load_i,
  input  logic              ack_s_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              timeout_o
);
  acc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CS_W-1:0]  sel_q;
  logic             ext_q, err_q, to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
      ext_q   <= 1'b0;
      err_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          sel_q <= sel_i;
          ext_q <= ext_i;
          cnt_q <= load_i;
          err_q <= reject_i;
          to_q  <= 1'b0;
          state_q <= reject_i ? ST_FIN : ST_ACT;
        end
        ST_ACT: begin
          if (ext_q && ack_s_i) begin
            state_q <= ST_FIN;
          end else if (cnt_q == '0) begin
            to_q    <= ext_q;
            state_q <= ST_FIN;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n_o[i] = !((state_q == ST_ACT) && (sel_q == CS_W'(i)));
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FIN);
  assign err_o     = done_o && err_q;
  assign timeout_o = done_o && to_q;

  // R5
  ack_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT && ext_q && ack_s_i) |=> (done_o && !timeout_o));
  // R2
  count_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT && cnt_q == '0) |=> done_o);
  // R8
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT) |=> $stable(sel_q));
endmodule

// File: rtl/smc_wait_timer.sv
module smc_wait_timer #(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8,
  parameter int EXT_W  = 16,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int CNT_W = (DLY_W > EXT_W) ? DLY_W : EXT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [CS_W-1:0]         sel_i,
  input  logic [NUM_CS-1:0]       wprot_i,
  input  logic [NUM_CS-1:0]       ext_en_i,
  input  logic [NUM_CS-1:0]       page_en_i,
  input  logic [NUM_CS*DLY_W-1:0] rd_dly_i,
  input  logic [NUM_CS*DLY_W-1:0] wr_dly_i,
  input  logic [EXT_W-1:0]        ext_dly_i,
  input  logic                    ack_i,
  output logic [NUM_CS-1:0]       cs_n_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic                    timeout_o
);
  logic             ack_s, reject, ext_mode;
  logic [CNT_W-1:0] load_val;

  smc_ack_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ack_i),
    .ack_s_o(ack_s)
  );

  smc_cfg_check #(.NUM_CS(NUM_CS), .DLY_W(DLY_W), .EXT_W(EXT_W)) u_cfg (
    .we_i     (we_i),
    .sel_i    (sel_i),
    .wprot_i  (wprot_i),
    .ext_en_i (ext_en_i),
    .page_en_i(page_en_i),
    .rd_dly_i (rd_dly_i),
    .wr_dly_i (wr_dly_i),
    .ext_dly_i(ext_dly_i),
    .reject_o (reject),
    .ext_o    (ext_mode),
    .load_o   (load_val)
  );

  smc_access_fsm #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .sel_i    (sel_i),
    .reject_i (reject),
    .ext_i    (ext_mode),
    .load_i   (load_val),
    .ack_s_i  (ack_s),
    .cs_n_o   (cs_n_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .timeout_o(timeout_o)
  );

  // R8
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && &cs_n_o));
  // R4
  to_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (done_o && !err_o));
  // R9
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

// File: tb/smc_wait_timer_tb.sv
module smc_wait_timer_tb_top;
  localparam int NUM_CS = 4;
  localparam int DLY_W  = 4;
  localparam int EXT_W  = 5;
  localparam int CS_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ack = 1'b0;
  logic [CS_W-1:0] sel = '0;
  logic [NUM_CS-1:0] wprot   = 4'b0100;
  logic [NUM_CS-1:0] ext_en  = 4'b1010;
  logic [NUM_CS-1:0] page_en = 4'b1001;
  logic [NUM_CS*DLY_W-1:0] rd_dly = '0, wr_dly = '0;
  logic [EXT_W-1:0] ext_dly = '0;
  logic [NUM_CS-1:0] cs_n;
  logic busy, done, err, tmo;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  smc_wait_timer #(.NUM_CS(NUM_CS), .DLY_W(DLY_W), .EXT_W(EXT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .sel_i(sel),
    .wprot_i(wprot), .ext_en_i(ext_en), .page_en_i(page_en),
    .rd_dly_i(rd_dly), .wr_dly_i(wr_dly), .ext_dly_i(ext_dly), .ack_i(ack),
    .cs_n_o(cs_n), .busy_o(busy), .done_o(done), .err_o(err), .timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // ack_at: negedge index (0 = request cycle) at which ack rises; -1 none
  task automatic run(input int cs, input bit wr, input int ack_at, input bit intrude,
                     input int exp_low, input bit exp_err, input bit exp_to, input string rq);
    int low = 0, stray = 0, n_done = 0;
    bit seen = 0, e = 0, t = 0, busy_ok = 1;
    @(negedge clk);
    req = 1'b1; we = wr; sel = CS_W'(cs);
    if (ack_at == 0) ack = 1'b1;
    for (int n = 1; n < 200 && !seen; n++) begin
      @(negedge clk);
      req = 1'b0;
      if (n == ack_at) ack = 1'b1;
      if (intrude && n == 2) begin req = 1'b1; sel = CS_W'((cs + 1) % NUM_CS); we = !wr; end
      if (!busy) busy_ok = 0;
      for (int i = 0; i < NUM_CS; i++)
        if (!cs_n[i]) begin
          if (i == cs) low++; else stray++;
        end
      if (done) begin seen = 1; n_done = n; e = err; t = tmo; end
    end
    chk(low == exp_low, {rq, " low cycles"}, low, exp_low);
    chk(n_done == exp_low + 1, {rq, " done cycle"}, n_done, exp_low + 1);
    chk(e == exp_err, {rq, " err"}, e, exp_err);
    chk(t == exp_to, {rq, " timeout"}, t, exp_to);
    chk(stray == 0, "R8 stray select", stray, 0);
    chk(busy_ok, "R9 busy through access", busy_ok, 1);
    req = 1'b0;
    ack = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R9 single done", done, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(cs_n == '1 && !done && !err && !tmo && !busy, "R1 reset state", cs_n, 15);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == '1 && !done && !busy, "R1 after release", cs_n, 15);

    for (int d = 0; d < 16; d++) begin
      rd_dly[0*DLY_W +: DLY_W] = DLY_W'(d);
      wr_dly[0*DLY_W +: DLY_W] = DLY_W'(15 - d);
      rd_dly[2*DLY_W +: DLY_W] = DLY_W'(15 - d);
      wr_dly[2*DLY_W +: DLY_W] = DLY_W'(d);
      // R2 (cs0 is page-only: normal timing per R7; ack ignored per R5)
      run(0, 1'b0, (d % 3 == 0) ? 0 : -1, 1'b0, d + 1, 1'b0, 1'b0, "R2 read cs0");
      // R3
      run(0, 1'b1, -1, 1'b0, 16 - d, 1'b0, 1'b0, "R3 write cs0");
      // R6 protected select
      run(2, 1'b0, -1, 1'b0, 16 - d, 1'b0, 1'b0, "R6 read protected cs2");
      run(2, 1'b1, -1, 1'b0, 0, 1'b1, 1'b0, "R6 write protected cs2");
    end

    for (int x = 0; x < 32; x++) begin
      ext_dly = EXT_W'(x);
      // R4
      run(1, 1'b0, -1, 1'b0, x + 1, 1'b0, 1'b1, "R4 ext read timeout");
      run(3, 1'b0, -1, 1'b0, 0, 1'b1, 1'b0, "R7 ext+page read");
      for (int j = 0; j <= x + 1; j++) begin
        int lo;
        lo = (j + 2 < x + 1) ? j + 2 : x + 1;
        // R5
        run(1, j[0], j, 1'b0, lo, 1'b0, (j + 2 > x + 1), "R5 ext ack");
      end
    end
    ext_dly = 5'd7;
    run(3, 1'b1, -1, 1'b0, 0, 1'b1, 1'b0, "R7 ext+page write");
    run(1, 1'b1, -1, 1'b0, 8, 1'b0, 1'b1, "R4 ext write timeout");

    rd_dly[0*DLY_W +: DLY_W] = 4'd5;
    // R8 request during access is ignored
    run(0, 1'b0, -1, 1'b1, 6, 1'b0, 1'b0, "R8 intruding request");
    chk(cs_n == '1, "R8 no access after intrusion", cs_n, 15);
    finish_up();
  end
endmodule